// File: doc/BRIEF.md
# Paired-Word Floating-Point Register File

This block is the register storage for a floating-point unit. The main array holds a parameterised number of 32-bit words (thirty-two by default). Each access names a register index and a width. A narrow access touches one word. A wide access treats an even index and the word above it as one 64-bit value: the higher-numbered word carries the upper half.

There are two combinational read ports and one write port. A write lands at the next rising clock edge. A read of a word that the current cycle's write will update already returns the new value. A merge stage takes the two 64-bit read-port values as sources and assembles a 64-bit result from a chosen half of each.

A small bank of 32-bit control registers sits beside the array, selected by a 2-bit code. It holds a fixed identification word, a control/status word and a condition word. A clear input empties the whole array in one cycle.

Top module: `fp_pair_regfile`

## Requirements
- R1: A narrow read (wide = 0) of index n returns word n on data bits 31:0, with bits 63:32 equal to zero.
- R2: A wide read of an even index n returns word n+1 on bits 63:32 and word n on bits 31:0.
- R3: A narrow write to index n stores data bits 31:0 into word n at the next rising edge. Bits 63:32 are ignored, and every other word keeps its value.
- R4: A wide write to an even index n stores data bits 63:32 into word n+1 and bits 31:0 into word n at the next rising edge. No other word changes.
- R5: A wide access with an odd index is illegal.
  - On a read port, the illegal flag is 1 and the data is zero.
  - On the write port, the illegal flag is 1 and no word changes.
- R6: When the write port is enabled and legal and clear is low, each word that the write will update is returned with its new value by any read port addressing it in the same cycle. This holds for both read widths.
- R7: The merge output depends on the 2-bit select, with A being read port 0's data and B being read port 1's data:
  - select 0 gives {A[31:0], B[31:0]};
  - select 1 gives {A[31:0], B[63:32]};
  - select 2 gives {A[63:32], B[31:0]};
  - select 3 gives {A[63:32], B[63:32]}.
- R8: Clear sets every array word to zero at the next rising edge.
  - Clear takes priority over a write in the same cycle, and that write is not forwarded.
  - The control registers are unaffected by clear.
- R9: The control bank is selected by a 2-bit code and read combinationally.
  - Code 0 returns the IMPL_ID parameter and ignores writes.
  - Code 1 is the 32-bit control/status word and code 2 is the 32-bit condition word; writes to either take effect at the next rising edge.
  - Code 3 reads zero and ignores writes.
- R10: After reset every array word, the control/status word and the condition word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Zero the whole array at the next edge |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port register index |
| wr_wide | input | 1 | Write port width: 1 = 64-bit pair |
| wr_data | input | 64 | Write port data |
| wr_illegal | output | 1 | Write request is a wide access at an odd index |
| rd0_idx | input | 5 | Read port 0 index |
| rd0_wide | input | 1 | Read port 0 width |
| rd0_data | output | 64 | Read port 0 data (merge source A) |
| rd0_illegal | output | 1 | Read port 0 wide access at an odd index |
| rd1_idx | input | 5 | Read port 1 index |
| rd1_wide | input | 1 | Read port 1 width |
| rd1_data | output | 64 | Read port 1 data (merge source B) |
| rd1_illegal | output | 1 | Read port 1 wide access at an odd index |
| mrg_sel | input | 2 | Half-merge selection |
| mrg_data | output | 64 | Half-merge result |
| ctl_sel | input | 2 | Control register selection |
| ctl_wr_en | input | 1 | Control register write enable |
| ctl_wr_data | input | 32 | Control register write data |
| ctl_rd_data | output | 32 | Control register read data |

## Verification
The properties assume that the index inputs stay below the number of registers, which the power-of-two register count guarantees. They also assume that no write, clear or select changes other than at the clock edge. The bench drives every input just after a falling edge and holds it across the following rising edge, so each registered effect is attributed to exactly one set of inputs. The stimulus sweeps every index at both widths and deliberately includes odd wide indexes, overlapping write/read pairs and clear together with a write. In those cases the properties constrain the outcome rather than the inputs.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int CTL_W = 32;

    typedef enum logic [1:0] {
        MRG_LO_LO = 2'd0,
        MRG_LO_HI = 2'd1,
        MRG_HI_LO = 2'd2,
        MRG_HI_HI = 2'd3
    } mrg_sel_e;

    typedef enum logic [1:0] {
        CTL_IDENT  = 2'd0,
        CTL_STATUS = 2'd1,
        CTL_COND   = 2'd2,
        CTL_SPARE  = 2'd3
    } ctl_sel_e;

    typedef struct packed {
        logic [CTL_W-1:0] status;
        logic [CTL_W-1:0] cond;
    } ctl_state_t;

endpackage

// File: rtl/fpr_word_array.sv
module fpr_word_array #(
    parameter int NUM_REGS = 32,
    parameter int WORD_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clear,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic                               wr_wide,
    input  logic [2*WORD_W-1:0]                wr_data,
    output logic                               wr_illegal,
    output logic [NUM_REGS-1:0]                wmask,
    output logic [NUM_REGS-1:0][WORD_W-1:0]    wval,
    output logic [NUM_REGS-1:0][WORD_W-1:0]    words_q
);

    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] words;
    } arr_state_t;

    arr_state_t       arr_d, arr_q;
    logic             wr_go;
    logic [IDX_W-1:0] hi_idx;

    assign wr_illegal = wr_en && wr_wide && wr_idx[0];
    assign wr_go      = wr_en && !wr_illegal && !clear;
    assign hi_idx     = {wr_idx[IDX_W-1:1], 1'b1};

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        logic lo_hit, hi_hit;
        assign lo_hit   = (wr_idx == IDX_W'(i));
        assign hi_hit   = wr_wide && (hi_idx == IDX_W'(i));
        assign wmask[i] = wr_go && (lo_hit || hi_hit);
        assign wval[i]  = hi_hit ? wr_data[2*WORD_W-1:WORD_W] : wr_data[WORD_W-1:0];
    end

    always_comb begin
        arr_d = arr_q;
        if (clear) begin
            arr_d.words = '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wmask[i]) arr_d.words[i] = wval[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    assign words_q = arr_q.words;

endmodule

// File: rtl/fpr_read_port.sv
module fpr_read_port #(
    parameter int NUM_REGS = 32,
    parameter int WORD_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] words,
    input  logic [NUM_REGS-1:0]             wmask,
    input  logic [NUM_REGS-1:0][WORD_W-1:0] wval,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            wide,
    output logic [2*WORD_W-1:0]             data,
    output logic                            illegal
);

    logic [IDX_W-1:0]  hi_idx;
    logic [WORD_W-1:0] lo_word, hi_word;

    assign hi_idx  = {idx[IDX_W-1:1], 1'b1};
    assign illegal = wide && idx[0];

    // Pending write data is returned ahead of the stored word.
    assign lo_word = wmask[idx]    ? wval[idx]    : words[idx];
    assign hi_word = wmask[hi_idx] ? wval[hi_idx] : words[hi_idx];

    always_comb begin
        if (illegal)   data = '0;
        else if (wide) data = {hi_word, lo_word};
        else           data = {{WORD_W{1'b0}}, lo_word};
    end

endmodule

// File: rtl/fpr_pair_merge.sv
module fpr_pair_merge #(
    parameter int WORD_W = 32
) (
    input  logic [2*WORD_W-1:0] src_a,
    input  logic [2*WORD_W-1:0] src_b,
    input  logic [1:0]          sel,
    output logic [2*WORD_W-1:0] result
);
    import fpr_pkg::*;

    logic [WORD_W-1:0] a_lo, a_hi, b_lo, b_hi;

    assign a_lo = src_a[WORD_W-1:0];
    assign a_hi = src_a[2*WORD_W-1:WORD_W];
    assign b_lo = src_b[WORD_W-1:0];
    assign b_hi = src_b[2*WORD_W-1:WORD_W];

    always_comb begin
        case (mrg_sel_e'(sel))
            MRG_LO_LO: result = {a_lo, b_lo};
            MRG_LO_HI: result = {a_lo, b_hi};
            MRG_HI_LO: result = {a_hi, b_lo};
            default:   result = {a_hi, b_hi};
        endcase
    end

endmodule

// File: rtl/fpr_ctl_regs.sv
module fpr_ctl_regs #(
    parameter logic [31:0] IMPL_ID = 32'h0001_0300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  sel,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);
    import fpr_pkg::*;

    ctl_state_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            case (ctl_sel_e'(sel))
                CTL_STATUS: ctl_d.status = wr_data;
                CTL_COND:   ctl_d.cond   = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (ctl_sel_e'(sel))
            CTL_IDENT:  rd_data = IMPL_ID;
            CTL_STATUS: rd_data = ctl_q.status;
            CTL_COND:   rd_data = ctl_q.cond;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fp_pair_regfile.sv
module fp_pair_regfile #(
    parameter int          NUM_REGS = 32,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] IMPL_ID  = 32'h0001_0300,
    localparam int         IDX_W    = $clog2(NUM_REGS),
    localparam int         DATA_W   = 2 * WORD_W,
    localparam int         NUM_RP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_wide,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic              rd0_wide,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_illegal,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic              rd1_wide,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_illegal,
    input  logic [1:0]        mrg_sel,
    output logic [DATA_W-1:0] mrg_data,
    input  logic [1:0]        ctl_sel,
    input  logic              ctl_wr_en,
    input  logic [31:0]       ctl_wr_data,
    output logic [31:0]       ctl_rd_data
);

    logic [NUM_REGS-1:0][WORD_W-1:0] words_q;
    logic [NUM_REGS-1:0][WORD_W-1:0] wval;
    logic [NUM_REGS-1:0]             wmask;

    logic [NUM_RP-1:0][IDX_W-1:0]  rp_idx;
    logic [NUM_RP-1:0]             rp_wide;
    logic [NUM_RP-1:0][DATA_W-1:0] rp_data;
    logic [NUM_RP-1:0]             rp_illegal;

    fpr_word_array #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_wide    (wr_wide),
        .wr_data    (wr_data),
        .wr_illegal (wr_illegal),
        .wmask      (wmask),
        .wval       (wval),
        .words_q    (words_q)
    );

    assign rp_idx  = {rd1_idx, rd0_idx};
    assign rp_wide = {rd1_wide, rd0_wide};

    for (genvar p = 0; p < NUM_RP; p++) begin : g_rport
        fpr_read_port #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_rport (
            .words   (words_q),
            .wmask   (wmask),
            .wval    (wval),
            .idx     (rp_idx[p]),
            .wide    (rp_wide[p]),
            .data    (rp_data[p]),
            .illegal (rp_illegal[p])
        );
    end

    assign rd0_data    = rp_data[0];
    assign rd1_data    = rp_data[1];
    assign rd0_illegal = rp_illegal[0];
    assign rd1_illegal = rp_illegal[1];

    fpr_pair_merge #(.WORD_W(WORD_W)) u_merge (
        .src_a  (rp_data[0]),
        .src_b  (rp_data[1]),
        .sel    (mrg_sel),
        .result (mrg_data)
    );

    fpr_ctl_regs #(.IMPL_ID(IMPL_ID)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (ctl_sel),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .rd_data (ctl_rd_data)
    );

endmodule

// File: rtl/fp_pair_regfile_chk.sv
module fp_pair_regfile_chk #(
    parameter int          NUM_REGS = 32,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] IMPL_ID  = 32'h0001_0300,
    localparam int         IDX_W    = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            clear,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic                            wr_wide,
    input logic [2*WORD_W-1:0]             wr_data,
    input logic [IDX_W-1:0]                rd0_idx,
    input logic                            rd0_wide,
    input logic [2*WORD_W-1:0]             rd0_data,
    input logic                            rd0_illegal,
    input logic [1:0]                      ctl_sel,
    input logic [31:0]                     ctl_rd_data,
    input logic [NUM_REGS-1:0][WORD_W-1:0] words_q
);

    // R3
    narrow_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_wide && !clear |=>
            words_q[$past(wr_idx)] == $past(wr_data[WORD_W-1:0]));

    // R5
    odd_wide_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_wide && wr_idx[0] && !clear |=> $stable(words_q));

    // R5
    odd_wide_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_wide && rd0_idx[0] |-> rd0_illegal && rd0_data == '0);

    // R6
    narrow_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_wide && !clear && !rd0_wide && rd0_idx == wr_idx |->
            rd0_data == {{WORD_W{1'b0}}, wr_data[WORD_W-1:0]});

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> words_q == '0);

    // R9
    ident_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sel == 2'd0 |-> ctl_rd_data == IMPL_ID);

endmodule

bind fp_pair_regfile fp_pair_regfile_chk #(
    .NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .IMPL_ID(IMPL_ID)
) u_chk (.*);

// File: tb/fp_pair_regfile_test.sv
module fp_pair_regfile_test;

    localparam int          N  = 32;
    localparam logic [31:0] ID = 32'h0001_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic        wr_wide = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_illegal;
    logic [4:0]  rd0_idx = '0;
    logic        rd0_wide = 1'b0;
    logic [63:0] rd0_data;
    logic        rd0_illegal;
    logic [4:0]  rd1_idx = '0;
    logic        rd1_wide = 1'b0;
    logic [63:0] rd1_data;
    logic        rd1_illegal;
    logic [1:0]  mrg_sel = '0;
    logic [63:0] mrg_data;
    logic [1:0]  ctl_sel = '0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] ctl_rd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [N];

    fp_pair_regfile uut (.*);

    always #4 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i, input logic [31:0] s);
        return (32'h0100_0001 * (i + 1)) ^ s;
    endfunction

    function automatic logic [63:0] model_rd(input int i, input logic w);
        if (w && i[0]) return 64'h0;
        if (w) return {mdl[i | 1], mdl[i]};
        return {32'h0, mdl[i]};
    endfunction

    task automatic wr(input int i, input logic w, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(i); wr_wide = w; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!(w && i[0])) begin
            mdl[i] = d[31:0];
            if (w) mdl[i + 1] = d[63:32];
        end
    endtask

    task automatic rd_all(input string tag);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            rd0_idx = 5'(i); rd0_wide = 1'b0;
            rd1_idx = 5'(i); rd1_wide = 1'b1;
            #1;
            chk({tag, " R1 narrow port0"}, rd0_data, model_rd(i, 1'b0));
            if (!i[0]) chk({tag, " R2 wide port1"}, rd1_data, model_rd(i, 1'b1));
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd_all("R10 reset");
        for (int s = 0; s < 3; s++) begin
            ctl_sel = 2'(s); #1;
            chk("R10 R9 ctl after reset", {32'h0, ctl_rd_data}, (s == 0) ? {32'h0, ID} : 64'h0);
        end

        // R3 narrow writes, upper data bits ignored
        for (int i = 0; i < N; i++) wr(i, 1'b0, {32'hDEAD_BEEF, pat(i, 32'h5A5A_0000)});
        rd_all("R3 after narrow sweep");

        // R4 wide writes over every even pair
        for (int i = 0; i < N; i += 2)
            wr(i, 1'b1, {pat(i + 1, 32'h00C3_3C00), pat(i, 32'h00C3_3C00)});
        rd_all("R4 after wide sweep");

        // R3 a narrow write leaves the neighbours alone
        wr(9, 1'b0, 64'hFFFF_FFFF_1234_5678);
        rd_all("R3 neighbour");

        // R5 odd wide write is flagged and inert
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd7; wr_wide = 1'b1; wr_data = 64'hBAD0_BAD1_BAD2_BAD3;
        #1;
        chk("R5 write flag", {63'h0, wr_illegal}, 64'h1);
        @(negedge clk);
        wr_en = 1'b0;
        rd_all("R5 odd wide write");

        // R5 odd wide read
        for (int i = 1; i < N; i += 2) begin
            rd0_idx = 5'(i); rd0_wide = 1'b1; rd1_idx = 5'(i); rd1_wide = 1'b1; #1;
            chk("R5 read data", rd0_data, 64'h0);
            chk("R5 read flag", {62'h0, rd1_illegal, rd0_illegal}, 64'h3);
        end

        // R6 forwarding: narrow write seen by narrow and wide reads
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd12; wr_wide = 1'b0; wr_data = 64'h0000_0000_CAFE_0012;
        rd0_idx = 5'd12; rd0_wide = 1'b0; rd1_idx = 5'd12; rd1_wide = 1'b1; #1;
        chk("R6 narrow fwd", rd0_data, 64'h0000_0000_CAFE_0012);
        chk("R6 wide read sees new low", rd1_data, {mdl[13], 32'hCAFE_0012});
        @(negedge clk);
        wr_en = 1'b0; mdl[12] = 32'hCAFE_0012;

        // R6 forwarding: wide write seen by a narrow read of the upper word
        wr_en = 1'b1; wr_idx = 5'd20; wr_wide = 1'b1; wr_data = 64'h2121_2121_2020_2020;
        rd0_idx = 5'd21; rd0_wide = 1'b0; rd1_idx = 5'd20; rd1_wide = 1'b1; #1;
        chk("R6 upper word fwd", rd0_data, 64'h0000_0000_2121_2121);
        chk("R6 pair fwd", rd1_data, 64'h2121_2121_2020_2020);
        @(negedge clk);
        wr_en = 1'b0; mdl[20] = 32'h2020_2020; mdl[21] = 32'h2121_2121;
        rd_all("R6 commit");

        // R7 merges over several source pairs
        for (int a = 0; a < N; a += 6) begin
            for (int m = 0; m < 4; m++) begin
                logic [63:0] av, bv, ex;
                rd0_idx = 5'(a); rd0_wide = 1'b1;
                rd1_idx = 5'((a + 10) % N); rd1_wide = 1'b1;
                mrg_sel = 2'(m); #1;
                av = model_rd(a, 1'b1); bv = model_rd((a + 10) % N, 1'b1);
                ex = {(m >= 2) ? av[63:32] : av[31:0], m[0] ? bv[63:32] : bv[31:0]};
                chk("R7 merge", mrg_data, ex);
            end
        end

        // R9 control bank
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            ctl_sel = 2'(s); ctl_wr_en = 1'b1; ctl_wr_data = 32'h7700_0000 + 32'(s);
            @(negedge clk);
            ctl_wr_en = 1'b0; #1;
            chk("R9 ctl readback", {32'h0, ctl_rd_data},
                (s == 0) ? {32'h0, ID} : (s == 3) ? 64'h0 : {32'h0, 32'h7700_0000 + 32'(s)});
        end

        // R8 clear beats a simultaneous write and is not forwarded
        @(negedge clk);
        clear = 1'b1; wr_en = 1'b1; wr_idx = 5'd4; wr_wide = 1'b0; wr_data = 64'h0000_0000_1111_2222;
        rd0_idx = 5'd4; rd0_wide = 1'b0; #1;
        chk("R8 no fwd under clear", rd0_data, model_rd(4, 1'b0));
        @(negedge clk);
        clear = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < N; i++) mdl[i] = '0;
        rd_all("R8 cleared");
        ctl_sel = 2'd1; #1;
        chk("R8 status kept", {32'h0, ctl_rd_data}, 64'h7700_0001);
        ctl_sel = 2'd2; #1;
        chk("R8 cond kept", {32'h0, ctl_rd_data}, 64'h7700_0002);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule